// File: doc/BRIEF.md
# Time-Slot Interchange Switch

This block is a non-blocking time-division switch for eight serial TDM lines. Every line carries a frame of 32 eight-bit channels, one bit per bit-clock tick, so a frame lasts 256 ticks. The block stores every incoming channel byte in a data memory. For each outgoing slot it looks up a connection-memory entry, fetches the byte it names and shifts that byte out MSB first. Any of the 256 input channels can feed any number of the 256 output slots at the same time.

Each output slot picks one of two delay modes. The minimum-delay mode takes the byte from the current frame when that byte has already arrived, and from the previous frame otherwise. The fixed mode always takes the previous frame, so a group of channels captured together leaves together and in order. A slot can instead send a byte the processor wrote into its connection entry, and a slot can release its line. A global drive enable can release all lines at once.

A host reaches a control register, both halves of the connection memory and the data memory through a synchronous non-multiplexed port. The port has a select, a read/write flag, a 6-bit address and 8-bit data. The data memory can only be read through this port.

Top module: `tsi_switch`

## Requirements
- R1: A high `frameStart` at a rising edge marks bit 7 of channel 0 on every `stIn` line at that edge. Channel c bit 7-k is sampled at the edge k+8c ticks later. The position counter then runs freely and wraps after 256 ticks.
- R2: The output byte of slot c of line s is driven MSB first. Its bit 7-k is on `stOut[s]` in the cycle that follows the edge at position 8c+k.
- R3: A connection source byte is {line[2:0] in bits 7:5, channel[4:0] in bits 4:0}. Any source may feed any slot, and one source may feed many slots in the same frame.
- R4: With the fixed-delay bit clear, a slot c whose source channel number is below c sends that source's byte from the same frame. Otherwise it sends the byte from the previous frame.
- R5: With the fixed-delay bit set, a slot always sends its source's byte from the previous frame.
- R6: With the message bit set, a slot sends the low connection byte itself.
- R7: With the enable bit clear, `stDrive[s]` is 0 and `stOut[s]` is 0 for all 8 ticks of that slot.
- R8: While `driveAll` is 0, every `stDrive` and `stOut` bit is 0, whatever the slot settings.
- R9: Address bit 5 = 0 selects the 8-bit control register, which reads back what was written. Its bits 2:0 pick the line and bits 4:3 pick the memory for accesses with address bit 5 = 1, where address bits 4:0 give the channel. The memory codes are 0 data, 1 connection low byte, 2 connection high byte, 3 none.
- R10: The connection high byte holds the enable bit in bit 0, the message bit in bit 1 and the fixed-delay bit in bit 2, with bits 7:3 read as 0. Both connection bytes read back as written.
- R11: A data-memory read returns the byte captured in the last completed frame for the selected line and channel. Writes with memory code 0 change nothing.
- R12: `rdata` is 0 unless `cs` and `rw` are both 1.
- R13: After reset, no line is driven, the control register reads 0 and every connection high byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frameStart | input | 1 | Frame alignment pulse for channel 0 bit 7 |
| stIn | input | 8 | Serial input lines |
| driveAll | input | 1 | Global output drive enable |
| cs | input | 1 | Host port select |
| rw | input | 1 | 1 read, 0 write |
| addr | input | 6 | Host address: bit 5 memory/control, bits 4:0 channel |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| stOut | output | 8 | Serial output data (0 when not driven) |
| stDrive | output | 8 | Per-line pad drive enable |

## Verification
On every cycle, assertions check that the position counter steps and realigns on the frame pulse and that the frame parity flips exactly at the wrap. They also check that a slot's drive state changes only at slot boundaries and that the read bus stays at zero while idle. The frame-by-frame choice between current and previous data, fan-out, message bytes, per-slot and global release, and the host register map can only be shown by the bench. The bench sweeps all 256 slots under several connection patterns and compares every output byte with values it works out arithmetically.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  localparam int BYTE_W = 8;

  // per-tick strobes from control to datapath
  typedef struct packed {
    logic capture;   // last bit of a channel is on the inputs
    logic load;      // first bit of a channel goes out next
    logic parity;    // buffer written during this frame
    logic cmWrSrc;   // host write, connection low byte
    logic cmWrCtl;   // host write, connection high byte
    logic rdCtl;     // host read of control register
    logic rdMem;     // host read of a memory
  } tsiStrobe_t;

  typedef struct packed {
    logic constDelay;
    logic msgMode;
    logic outEn;
  } slotCtl_t;

  typedef enum logic [1:0] {
    SEL_DATA     = 2'd0,
    SEL_CONN_SRC = 2'd1,
    SEL_CONN_CTL = 2'd2,
    SEL_NONE     = 2'd3
  } memSel_t;

endpackage

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
#(
  parameter int NUM_STREAMS = 8,
  parameter int NUM_CH = 32,
  localparam int SW = $clog2(NUM_STREAMS),
  localparam int CW = $clog2(NUM_CH),
  localparam int POSW = CW + 3,
  localparam int AW = CW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frameStart,
  input  logic              cs,
  input  logic              rw,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wdata,
  output tsiStrobe_t        strb,
  output logic [CW-1:0]     curChan,
  output logic [SW-1:0]     selStream,
  output memSel_t           memSel,
  output logic [CW-1:0]     cpuChan,
  output logic [BYTE_W-1:0] ctlView
);

  localparam logic [POSW-1:0] LAST = POSW'(NUM_CH * 8 - 1);

  logic [POSW-1:0]   pos;
  logic [POSW-1:0]   cur;
  logic [POSW-1:0]   posNext;
  logic              parity;
  logic [BYTE_W-1:0] ctlReg;
  logic              wrCtlReg;
  logic              memAcc;

  always_comb begin
    cur     = frameStart ? '0 : pos;
    posNext = (cur == LAST) ? '0 : cur + POSW'(1);
  end

  assign memAcc   = cs && addr[AW-1];
  assign wrCtlReg = cs && !rw && !addr[AW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= '0;
      parity <= 1'b0;
      ctlReg <= '0;
    end else begin
      pos    <= posNext;
      parity <= parity ^ (cur == LAST);
      if (wrCtlReg) ctlReg <= wdata;
    end
  end

  assign curChan   = cur[POSW-1:3];
  assign selStream = ctlReg[SW-1:0];
  assign memSel    = memSel_t'(ctlReg[SW+:2]);
  assign cpuChan   = addr[CW-1:0];
  assign ctlView   = ctlReg;

  always_comb begin
    strb.capture = (cur[2:0] == 3'd7);
    strb.load    = (cur[2:0] == 3'd0);
    strb.parity  = parity;
    strb.cmWrSrc = memAcc && !rw && (memSel == SEL_CONN_SRC);
    strb.cmWrCtl = memAcc && !rw && (memSel == SEL_CONN_CTL);
    strb.rdCtl   = cs && rw && !addr[AW-1];
    strb.rdMem   = memAcc && rw;
  end

  // R1: free-running position counter
  a_r1_pos_step: assert property (@(posedge clk) disable iff (rst)
    !frameStart |=> (pos == (($past(pos) == LAST) ? '0 : $past(pos) + POSW'(1))));

  // R1: frame pulse realigns to position 0
  a_r1_frame_align: assert property (@(posedge clk) disable iff (rst)
    frameStart |=> (pos == POSW'(1)));

  // R5: buffer parity swaps exactly at frame wrap
  a_r5_parity_flip: assert property (@(posedge clk) disable iff (rst)
    (!frameStart && pos == LAST) |=> (parity != $past(parity)));

endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath
  import tsi_pkg::*;
#(
  parameter int NUM_STREAMS = 8,
  parameter int NUM_CH = 32,
  localparam int SW = $clog2(NUM_STREAMS),
  localparam int CW = $clog2(NUM_CH),
  localparam int IW = SW + CW,
  localparam int DEPTH = NUM_STREAMS * NUM_CH
) (
  input  logic                   clk,
  input  logic                   rst,
  input  tsiStrobe_t             strb,
  input  logic [CW-1:0]          curChan,
  input  logic [NUM_STREAMS-1:0] stIn,
  input  logic [SW-1:0]          selStream,
  input  memSel_t                memSel,
  input  logic [CW-1:0]          cpuChan,
  input  logic [BYTE_W-1:0]      wdata,
  input  logic [BYTE_W-1:0]      ctlView,
  output logic [NUM_STREAMS-1:0] txBit,
  output logic [NUM_STREAMS-1:0] txDrive,
  output logic [BYTE_W-1:0]      rdata
);

  logic [BYTE_W-2:0] rxShift [NUM_STREAMS];
  logic [BYTE_W-1:0] dataMem [2][DEPTH];
  logic [BYTE_W-1:0] cmSrc   [DEPTH];
  slotCtl_t          cmCtl   [DEPTH];
  logic [BYTE_W-1:0] txShift [NUM_STREAMS];
  logic [NUM_STREAMS-1:0] txEn;
  logic [BYTE_W-1:0] fetched [NUM_STREAMS];
  logic [NUM_STREAMS-1:0] fetchEn;
  logic [IW-1:0]     cpuIdx;

  assign cpuIdx = {selStream, cpuChan};

  // serial-to-parallel capture
  always_ff @(posedge clk) begin
    for (int s = 0; s < NUM_STREAMS; s++) begin
      rxShift[s] <= {rxShift[s][BYTE_W-3:0], stIn[s]};
    end
  end

  // double-buffered data memory, written on the last bit of each channel
  always_ff @(posedge clk) begin
    if (strb.capture) begin
      for (int s = 0; s < NUM_STREAMS; s++) begin
        dataMem[strb.parity][{SW'(s), curChan}] <= {rxShift[s], stIn[s]};
      end
    end
  end

  // connection memory
  always_ff @(posedge clk) begin
    if (strb.cmWrSrc) cmSrc[cpuIdx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cmCtl[i] <= '0;
    end else if (strb.cmWrCtl) begin
      cmCtl[cpuIdx] <= slotCtl_t'(wdata[2:0]);
    end
  end

  // per-line fetch for the channel that starts next
  for (genvar gs = 0; gs < NUM_STREAMS; gs++) begin : g_fetch
    logic [IW-1:0]     slotIdx;
    logic [BYTE_W-1:0] src;
    slotCtl_t          ctl;
    logic [CW-1:0]     srcCh;
    logic [SW-1:0]     srcSt;
    logic              useCur;
    logic              rdBuf;

    assign slotIdx = {SW'(gs), curChan};
    assign src     = cmSrc[slotIdx];
    assign ctl     = cmCtl[slotIdx];
    assign srcCh   = src[CW-1:0];
    assign srcSt   = src[CW+:SW];
    assign useCur  = !ctl.constDelay && (srcCh < curChan);
    assign rdBuf   = useCur ? strb.parity : ~strb.parity;
    assign fetched[gs] = ctl.msgMode ? src : dataMem[rdBuf][{srcSt, srcCh}];
    assign fetchEn[gs] = ctl.outEn;
  end

  // parallel-to-serial output
  always_ff @(posedge clk) begin
    if (rst) begin
      txEn <= '0;
      for (int s = 0; s < NUM_STREAMS; s++) txShift[s] <= '0;
    end else if (strb.load) begin
      txEn <= fetchEn;
      for (int s = 0; s < NUM_STREAMS; s++) txShift[s] <= fetched[s];
    end else begin
      for (int s = 0; s < NUM_STREAMS; s++) txShift[s] <= txShift[s] << 1;
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_STREAMS; s++) txBit[s] = txShift[s][BYTE_W-1];
  end
  assign txDrive = txEn;

  // host read mux
  always_comb begin
    rdata = '0;
    if (strb.rdCtl) begin
      rdata = ctlView;
    end else if (strb.rdMem) begin
      case (memSel)
        SEL_DATA:     rdata = dataMem[~strb.parity][cpuIdx];
        SEL_CONN_SRC: rdata = cmSrc[cpuIdx];
        SEL_CONN_CTL: rdata = {{(BYTE_W-3){1'b0}}, cmCtl[cpuIdx]};
        default:      rdata = '0;
      endcase
    end
  end

  // R7: a slot's drive state changes only at a slot boundary
  a_r7_drive_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> $stable(txEn));

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int NUM_STREAMS = 8,
  parameter int NUM_CH = 32,
  localparam int SW = $clog2(NUM_STREAMS),
  localparam int CW = $clog2(NUM_CH),
  localparam int AW = CW + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   frameStart,
  input  logic [NUM_STREAMS-1:0] stIn,
  input  logic                   driveAll,
  input  logic                   cs,
  input  logic                   rw,
  input  logic [AW-1:0]          addr,
  input  logic [BYTE_W-1:0]      wdata,
  output logic [BYTE_W-1:0]      rdata,
  output logic [NUM_STREAMS-1:0] stOut,
  output logic [NUM_STREAMS-1:0] stDrive
);

  tsiStrobe_t             strb;
  logic [CW-1:0]          curChan;
  logic [SW-1:0]          selStream;
  memSel_t                memSel;
  logic [CW-1:0]          cpuChan;
  logic [BYTE_W-1:0]      ctlView;
  logic [NUM_STREAMS-1:0] txBit;
  logic [NUM_STREAMS-1:0] txDrive;

  tsi_ctrl #(.NUM_STREAMS(NUM_STREAMS), .NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst(rst), .frameStart(frameStart),
    .cs(cs), .rw(rw), .addr(addr), .wdata(wdata),
    .strb(strb), .curChan(curChan), .selStream(selStream),
    .memSel(memSel), .cpuChan(cpuChan), .ctlView(ctlView)
  );

  tsi_datapath #(.NUM_STREAMS(NUM_STREAMS), .NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .curChan(curChan), .stIn(stIn),
    .selStream(selStream), .memSel(memSel), .cpuChan(cpuChan),
    .wdata(wdata), .ctlView(ctlView),
    .txBit(txBit), .txDrive(txDrive), .rdata(rdata)
  );

  assign stDrive = txDrive & {NUM_STREAMS{driveAll}};
  assign stOut   = txBit & stDrive;

  // R12: read bus idles at zero
  a_r12_rdata_idle: assert property (@(posedge clk) disable iff (rst)
    !(cs && rw) |-> (rdata == '0));

endmodule

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int NC = 32;
  localparam int FRAME = NC * 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frameStart = 1'b0;
  logic [NS-1:0] stIn = '0;
  logic driveAll = 1'b1;
  logic cs = 1'b0;
  logic rw = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [NS-1:0] stOut;
  logic [NS-1:0] stDrive;

  int checks = 0;
  int errors = 0;

  logic [7:0] mSrc [NS][NC];
  bit mEn [NS][NC];
  bit mMsg [NS][NC];
  bit mConst [NS][NC];

  tsi_switch u_dut (
    .clk(clk), .rst(rst), .frameStart(frameStart), .stIn(stIn),
    .driveAll(driveAll), .cs(cs), .rw(rw), .addr(addr), .wdata(wdata),
    .rdata(rdata), .stOut(stOut), .stDrive(stDrive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input int f, input int s, input int c);
    return 8'(f * 53 + s * 29 + c * 7 + 11);
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  task automatic busWrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rw = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rw = 1'b1; addr = a;
    #1 d = rdata;
    cs = 1'b0; rw = 1'b0;
  endtask

  task automatic writeConfig();
    for (int s = 0; s < NS; s++) begin
      busWrite(6'h00, 8'((1 << 3) | s));
      for (int c = 0; c < NC; c++) busWrite(6'(32 | c), mSrc[s][c]);
      busWrite(6'h00, 8'((2 << 3) | s));
      for (int c = 0; c < NC; c++)
        busWrite(6'(32 | c), {5'b0, mConst[s][c], mMsg[s][c], mEn[s][c]});
    end
  endtask

  task automatic checkSlot(input int f, input int os, input int oc, input bit drvAll,
                           input logic [7:0] drv, input logic [7:0] dat);
    logic [7:0] src;
    logic [7:0] b;
    int ss;
    int sc;
    int fu;
    bit en;
    string tag;
    src = mSrc[os][oc];
    ss = int'(src[7:5]);
    sc = int'(src[4:0]);
    if (!drvAll) tag = "R8";
    else if (!mEn[os][oc]) tag = "R7";
    else if (mMsg[os][oc]) tag = "R6";
    else if (mConst[os][oc]) tag = "R5";
    else tag = "R4";
    fu = (mConst[os][oc] || sc >= oc) ? f - 1 : f;
    b = mMsg[os][oc] ? src : pat(fu, ss, sc);
    en = drvAll && mEn[os][oc];
    check({drv, dat}, {en ? 8'hFF : 8'h00, en ? b : 8'h00},
          $sformatf("%s line %0d slot %0d frame %0d", tag, os, oc, f));
  endtask

  // R1, R2: bits driven and sampled at positions counted from frameStart
  task automatic runFrames(input int nFrames, input bit drvAll);
    logic [7:0] drvBits [NS];
    logic [7:0] datBits [NS];
    logic [7:0] v;
    driveAll = drvAll;
    for (int g = 0; g <= nFrames * FRAME; g++) begin
      @(negedge clk);
      if (g > 0) begin
        int q;
        int f;
        int p;
        int c;
        int k;
        q = g - 1; f = q / FRAME; p = q % FRAME; c = p / 8; k = p % 8;
        for (int s = 0; s < NS; s++) begin
          drvBits[s][7-k] = stDrive[s];
          datBits[s][7-k] = stOut[s];
        end
        if (k == 7 && f >= 1)
          for (int s = 0; s < NS; s++) checkSlot(f, s, c, drvAll, drvBits[s], datBits[s]);
      end
      if (g < nFrames * FRAME) begin
        frameStart = (g % FRAME == 0);
        for (int s = 0; s < NS; s++) begin
          v = pat(g / FRAME, s, (g % FRAME) / 8);
          stIn[s] = v[7 - (g % 8)];
        end
      end else begin
        frameStart = 1'b0;
        stIn = '0;
      end
    end
    driveAll = 1'b1;
  endtask

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R13 reset state
    @(negedge clk);
    check({8'h0, stDrive}, 16'h0, "R13 drive after reset");
    check({8'h0, rdata}, 16'h0, "R12 idle read bus");
    busRead(6'h00, d);
    check({8'h0, d}, 16'h0, "R13 control register reset");
    busWrite(6'h00, 8'((2 << 3) | 3));
    busRead(6'h25, d);
    check({8'h0, d}, 16'h0, "R13 connection high byte reset");

    // R9 control register
    busWrite(6'h00, 8'hD5);
    busRead(6'h00, d);
    check({8'h0, d}, 16'h00D5, "R9 control register readback");
    busWrite(6'h00, 8'h18);
    @(negedge clk);
    cs = 1'b1; rw = 1'b0; addr = 6'h20;
    #1 check({8'h0, rdata}, 16'h0, "R12 read bus during write");
    cs = 1'b0;

    // R3, R4: permutation, minimum-delay mode, sources both before and after slot
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++) begin
        mSrc[s][c] = {3'((s + 3) % NS), 5'((c * 5 + s) % NC)};
        mEn[s][c] = 1'b1; mMsg[s][c] = 1'b0; mConst[s][c] = 1'b0;
      end
    writeConfig();
    runFrames(3, 1'b1);

    // R11 data memory holds the last completed frame; writes ignored
    for (int s = 0; s < NS; s++) begin
      busWrite(6'h00, 8'(s));
      busRead(6'(32 | (s * 3 + 1)), d);
      check({8'h0, d}, {8'h0, pat(2, s, s * 3 + 1)}, $sformatf("R11 data read line %0d", s));
    end
    busWrite(6'h00, 8'd4);
    busWrite(6'h29, 8'h00);
    busRead(6'h29, d);
    check({8'h0, d}, {8'h0, pat(2, 4, 9)}, "R11 data write ignored");

    // R10 connection readback
    busWrite(6'h00, 8'((1 << 3) | 2));
    busRead(6'h27, d);
    check({8'h0, d}, {8'h0, mSrc[2][7]}, "R10 connection low readback");
    busWrite(6'h00, 8'((2 << 3) | 2));
    busRead(6'h27, d);
    check({8'h0, d}, 16'h0001, "R10 connection high readback");

    // R5 fixed delay, reversed map; R3 fan-out of one source to all of line 0
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++) begin
        mSrc[s][c] = (s == 0) ? {3'd5, 5'd10} : {3'(NS - 1 - s), 5'(NC - 1 - c)};
        mEn[s][c] = 1'b1; mMsg[s][c] = 1'b0; mConst[s][c] = 1'b1;
      end
    writeConfig();
    runFrames(3, 1'b1);

    // R6, R7 and mixed delay modes
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++) begin
        mMsg[s][c] = (c % 4 == 0);
        mEn[s][c] = (c % 4 != 1);
        mConst[s][c] = (c % 4 == 2);
        case (c % 4)
          0: mSrc[s][c] = 8'((s * 16 + c) ^ 8'hA5);
          1: mSrc[s][c] = 8'(s * 7 + c);
          2: mSrc[s][c] = {3'(s), 5'(c ^ 1)};
          default: mSrc[s][c] = {3'((s + 1) % NS), 5'(c ^ 1)};
        endcase
      end
    writeConfig();
    busWrite(6'h00, 8'((2 << 3) | 6));
    busRead(6'h22, d);
    check({8'h0, d}, 16'h0005, "R10 high byte fixed-delay and enable bits");
    runFrames(3, 1'b1);

    // R8 global release
    runFrames(2, 1'b0);

    report();
  end

endmodule